// File: doc/BRIEF.md
# FIFO Level Request Generator

This block sits between a system-side data mover and the serializer of an audio serial port. It holds a transmit queue and a receive queue. It keeps a running occupancy count for each queue and compares those counts against six programmable thresholds. For each direction there is one threshold per DMA channel and one for the interrupt. Each comparison result is masked by its own enable bit. The masked results are merged into two DMA request lines and one interrupt line, and all three are registered.

On the transmit side a comparator fires while the threshold is at or above the current fill, meaning room is available and more words are wanted. On the receive side a comparator fires while the threshold is at or below the current fill, meaning enough words are waiting to be drained. Software sees the unmasked merged results, both fill counts and four sticky error flags in a read-only status word. Thresholds and enables are written through a small register port and take effect on the next clock.

All four data ports use valid/ready. A word moves only on a cycle where valid and ready are both high. A writer must hold valid and data steady while ready is low. A reader may raise ready at any time, and data is taken only while valid is high. Words leave each queue in arrival order.

Top module: `fifo_level_req`

## Requirements
- R1: Each queue holds up to DEPTH words and delivers them in the order they were accepted. `*_in_ready` is low exactly while the queue holds DEPTH words. `*_out_valid` is high exactly while the queue holds at least one word, and `*_out_data` then shows the oldest word.
- R2: Each fill count rises by one on an accepted write and falls by one on an accepted read. It stays unchanged when both happen in the same cycle. The transmit count is readable at status bits [7:4] and the receive count at status bits [11:8].
- R3: Two conditions set sticky flags and change neither the count nor the stored data. Valid high while a queue is full sets its overflow flag. Ready high on the output while a queue is empty sets its underflow flag. The flags sit at status bit 12 (transmit overflow), 13 (transmit underflow), 14 (receive overflow) and 15 (receive underflow), and only reset clears them.
- R4: A transmit comparator (threshold fields 0, 2 and 4) is true while its threshold is greater than or equal to the transmit fill count.
- R5: A receive comparator (threshold fields 1, 3 and 5) is true while its threshold is less than or equal to the receive fill count.
- R6: `dma_req[0]` is (comparator 0 AND enable bit 0) OR (comparator 1 AND enable bit 1).
- R7: `dma_req[1]` is (comparator 2 AND enable bit 2) OR (comparator 3 AND enable bit 3).
- R8: `irq` is (comparator 4 AND enable bit 4) OR (comparator 5 AND enable bit 5).
- R9: Status bit 0 is comparator 0 OR 1, bit 1 is comparator 2 OR 3, and bit 2 is comparator 4 OR 5. All three are independent of the enables.
- R10: The request outputs and status bits [2:0] are registered. They reflect a change in a fill count, a threshold or an enable exactly one clock after that change is visible.
- R11: After reset both queues are empty, all thresholds and enables are zero, and the request outputs are low. From the first clock after reset, status bits [2:0] read 3'b111, because every comparator holds with a fill of zero and a threshold of zero.
- R12: The register map has three addresses. Address 0 holds the six threshold fields, field i at bits [4i+3:4i]. Address 1 holds the enables, enable i at bit i. Address 2 holds the read-only status. A write lands on the next clock edge and reads back at once, and a write to address 2 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | System offers a transmit word |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | WIDTH | Transmit word from the system |
| tx_out_valid | output | 1 | Transmit word available to the serializer |
| tx_out_ready | input | 1 | Serializer takes a transmit word |
| tx_out_data | output | WIDTH | Oldest transmit word |
| rx_in_valid | input | 1 | Deserializer offers a receive word |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | WIDTH | Receive word from the deserializer |
| rx_out_valid | output | 1 | Receive word available to the system |
| rx_out_ready | input | 1 | System takes a receive word |
| rx_out_data | output | WIDTH | Oldest receive word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 6*$clog2(DEPTH+1) | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dma_req | output | 2 | Masked DMA request lines |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench builds the block with its default parameters: eight-word queues of 32-bit words and 4-bit counts and thresholds. With these values every fill level from 0 to 8 can be reached in a few cycles, including the full and empty edges where the overflow and underflow flags trigger. A threshold of 15 lies beyond any reachable fill. That makes a transmit comparator stuck true and a receive comparator stuck false, so both comparison senses can be probed at their extremes as well as at exact equality.

// File: rtl/fifo_req_pkg.sv
package fifo_req_pkg;
  localparam int NUM_CMP = 6;

  typedef enum logic [1:0] {
    ADDR_DEPTH  = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_STATUS = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [LW-1:0]    level,
  output logic             ovf,
  output logic             unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, push, pop;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push      = in_valid && !full;
  assign pop       = out_ready && !empty;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      ovf <= ovf | (in_valid && full);
      unf <= unf | (out_ready && empty);
    end
  end
endmodule

// File: rtl/thresh_cmp.sv
module thresh_cmp #(
  parameter int LW    = 4,
  parameter bit IS_TX = 1'b1
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] depth,
  output logic          hit
);
  generate
    if (IS_TX) begin : g_room
      assign hit = (depth >= level);
    end else begin : g_data
      assign hit = (depth <= level);
    end
  endgenerate
endmodule

// File: rtl/req_gate.sv
module req_gate #(
  parameter int NCMP = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMP-1:0] hit,
  input  logic [NCMP-1:0] en,
  output logic [NCMP/2-1:0] req,
  output logic [NCMP/2-1:0] raw
);
  localparam int NGRP = NCMP / 2;

  logic [NCMP-1:0] hit_q;
  logic [NGRP-1:0] req_d;

  generate
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
      assign req_d[k] = |(hit[2*k +: 2] & en[2*k +: 2]);
      assign raw[k]   = |hit_q[2*k +: 2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      req   <= '0;
    end else begin
      hit_q <= hit;
      req   <= req_d;
    end
  end
endmodule

// File: rtl/fifo_level_req.sv
module fifo_level_req
  import fifo_req_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tx_in_valid,
  output logic                              tx_in_ready,
  input  logic [WIDTH-1:0]                  tx_in_data,
  output logic                              tx_out_valid,
  input  logic                              tx_out_ready,
  output logic [WIDTH-1:0]                  tx_out_data,
  input  logic                              rx_in_valid,
  output logic                              rx_in_ready,
  input  logic [WIDTH-1:0]                  rx_in_data,
  output logic                              rx_out_valid,
  input  logic                              rx_out_ready,
  output logic [WIDTH-1:0]                  rx_out_data,
  input  logic                              reg_wr_en,
  input  logic [1:0]                        reg_addr,
  input  logic [6*$clog2(DEPTH+1)-1:0]      reg_wdata,
  output logic [31:0]                       reg_rdata,
  output logic [1:0]                        dma_req,
  output logic                              irq
);
  localparam int LW     = $clog2(DEPTH + 1);
  localparam int DW     = NUM_CMP * LW;
  localparam int ST_TXL = 4;
  localparam int ST_RXL = ST_TXL + LW;
  localparam int ST_FLG = ST_RXL + LW;

  logic [LW-1:0]      tx_level, rx_level;
  logic               tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [DW-1:0]      depth_q;
  logic [NUM_CMP-1:0] en_q;
  logic [NUM_CMP-1:0] hit;
  logic [2:0]         req, raw;

  req_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .ovf(tx_ovf), .unf(tx_unf)
  );

  req_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .ovf(rx_ovf), .unf(rx_unf)
  );

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      thresh_cmp #(.LW(LW), .IS_TX((i % 2) == 0)) u_cmp (
        .level(((i % 2) == 0) ? tx_level : rx_level),
        .depth(depth_q[i*LW +: LW]),
        .hit(hit[i])
      );
    end
  endgenerate

  req_gate #(.NCMP(NUM_CMP)) u_gate (
    .clk(clk), .rst_n(rst_n), .hit(hit), .en(en_q), .req(req), .raw(raw)
  );

  assign dma_req = req[1:0];
  assign irq     = req[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      en_q    <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == ADDR_DEPTH)  depth_q <= reg_wdata[DW-1:0];
      if (reg_addr == ADDR_ENABLE) en_q    <= reg_wdata[NUM_CMP-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_DEPTH:  reg_rdata[DW-1:0]      = depth_q;
      ADDR_ENABLE: reg_rdata[NUM_CMP-1:0] = en_q;
      ADDR_STATUS: begin
        reg_rdata[2:0]            = raw;
        reg_rdata[ST_TXL +: LW]   = tx_level;
        reg_rdata[ST_RXL +: LW]   = rx_level;
        reg_rdata[ST_FLG +: 4]    = {rx_unf, rx_ovf, tx_unf, tx_ovf};
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/req_chk.sv
module req_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] tx_level,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic          tx_ovf,
  input logic [5:0]    en,
  input logic [1:0]    dma_req,
  input logic          irq,
  input logic [2:0]    raw
);
  p_full_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(DEPTH)) |-> !tx_in_ready);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == $past(tx_level)) || (tx_level == $past(tx_level) + 1'b1) ||
    (tx_level + 1'b1 == $past(tx_level)));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_in_ready) |=> tx_ovf);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);

  p_dma0_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[0] |-> $past(en[0] | en[1]));

  p_dma1_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[1] |-> $past(en[2] | en[3]));

  p_irq_has_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw[2]);
endmodule

bind fifo_level_req req_chk #(.DEPTH(DEPTH), .LW(LW)) u_req_chk (
  .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_in_valid(tx_in_valid),
  .tx_in_ready(tx_in_ready), .tx_ovf(tx_ovf), .en(en_q), .dma_req(dma_req),
  .irq(irq), .raw(raw)
);

// File: tb/tb_fifo_level_req.sv
module tb_fifo_level_req;
  localparam int W = 32, D = 8, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_in_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_out_ready = 0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [W-1:0] tx_in_data = '0, rx_in_data = '0, tx_out_data, rx_out_data;
  logic reg_wr_en = 0;
  logic [1:0] reg_addr = 0;
  logic [6*LW-1:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0] dma_req;
  logic irq;

  fifo_level_req #(.WIDTH(W), .DEPTH(D)) dut (.*);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int tx_lvl = 0, rx_lvl = 0;
  logic [LW-1:0] dep [6];
  logic [5:0] en = '0;
  logic [3:0] flg = '0; // {rx_unf, rx_ovf, tx_unf, tx_ovf}
  logic [W-1:0] txq[$], rxq[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic bit hit(int i);
    if (i % 2 == 0) return dep[i] >= LW'(tx_lvl);
    return dep[i] <= LW'(rx_lvl);
  endfunction

  task automatic check_req(string tag);
    logic [31:0] st;
    logic [2:0] r, m;
    for (int k = 0; k < 3; k++) begin
      r[k] = hit(2*k) | hit(2*k+1);
      m[k] = (hit(2*k) & en[2*k]) | (hit(2*k+1) & en[2*k+1]);
    end
    chk({tag, "/R6"}, "dma_req[0]", 32'(dma_req[0]), 32'(m[0]));
    chk({tag, "/R7"}, "dma_req[1]", 32'(dma_req[1]), 32'(m[1]));
    chk({tag, "/R8"}, "irq", 32'(irq), 32'(m[2]));
    rd(2'd2, st);
    chk({tag, "/R9"}, "status raw", 32'(st[2:0]), 32'(r));
    chk({tag, "/R2"}, "tx level", 32'(st[7:4]), 32'(tx_lvl));
    chk({tag, "/R2"}, "rx level", 32'(st[11:8]), 32'(rx_lvl));
    chk({tag, "/R3"}, "flags", 32'(st[15:12]), 32'(flg));
  endtask

  task automatic wr(input logic [1:0] a, input logic [6*LW-1:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 0;
    if (a == 0) for (int i = 0; i < 6; i++) dep[i] = d[4*i +: 4];
    if (a == 1) en = d[5:0];
  endtask

  task automatic push(bit is_rx, logic [W-1:0] d);
    if (!is_rx) begin
      tx_in_valid = 1; tx_in_data = d; step(); tx_in_valid = 0;
      if (tx_lvl < D) begin tx_lvl++; txq.push_back(d); end else flg[0] = 1;
    end else begin
      rx_in_valid = 1; rx_in_data = d; step(); rx_in_valid = 0;
      if (rx_lvl < D) begin rx_lvl++; rxq.push_back(d); end else flg[2] = 1;
    end
  endtask

  task automatic pop(bit is_rx, string tag);
    logic [W-1:0] e;
    if (!is_rx) begin
      chk(tag, "tx_out_valid", 32'(tx_out_valid), 32'(tx_lvl > 0));
      if (tx_lvl > 0) begin e = txq.pop_front(); chk(tag, "tx_out_data", tx_out_data, e); end
      tx_out_ready = 1; step(); tx_out_ready = 0;
      if (tx_lvl > 0) tx_lvl--; else flg[1] = 1;
    end else begin
      chk(tag, "rx_out_valid", 32'(rx_out_valid), 32'(rx_lvl > 0));
      if (rx_lvl > 0) begin e = rxq.pop_front(); chk(tag, "rx_out_data", rx_out_data, e); end
      rx_out_ready = 1; step(); rx_out_ready = 0;
      if (rx_lvl > 0) rx_lvl--; else flg[3] = 1;
    end
  endtask

  task automatic drain(string tag);
    while (tx_lvl > 0) pop(0, tag);
    while (rx_lvl > 0) pop(1, tag);
    step();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11", "dma_req", 32'(dma_req), 0);
    chk("R11", "irq", 32'(irq), 0);
    chk("R11", "tx_in_ready", 32'(tx_in_ready), 1);
    chk("R11", "rx_out_valid", 32'(rx_out_valid), 0);
    rd(2'd0, v); chk("R11", "depth word", v, 0);
    rd(2'd1, v); chk("R11", "enable word", v, 0);
    rd(2'd2, v); chk("R11", "status raw", 32'(v[2:0]), 32'h7);
    check_req("R11");
  endtask

  task automatic t_order();
    for (int i = 0; i < D; i++) push(0, 32'hA500_0000 + i);
    chk("R1", "tx_in_ready when full", 32'(tx_in_ready), 0);
    for (int i = 0; i < 3; i++) push(1, 32'h5A00_0010 + i);
    chk("R1", "rx_in_ready partly filled", 32'(rx_in_ready), 1);
    step(); check_req("R1");
    for (int i = 0; i < D; i++) pop(0, "R1");
    for (int i = 0; i < 3; i++) pop(1, "R1");
    step(); check_req("R1");
  endtask

  task automatic t_simul();
    logic [W-1:0] e;
    for (int i = 0; i < 3; i++) push(1, 32'hC0DE_0000 + i);
    e = rxq.pop_front();
    chk("R2", "rx head before dual", rx_out_data, e);
    rx_in_valid = 1; rx_out_ready = 1; rx_in_data = 32'hC0DE_00FF;
    step();
    rx_in_valid = 0; rx_out_ready = 0;
    rxq.push_back(32'hC0DE_00FF);
    step(); check_req("R2");
    drain("R2");
  endtask

  task automatic t_flags();
    for (int i = 0; i < D; i++) push(0, 32'h0F00_0000 + i);
    push(0, 32'hDEAD_BEEF);
    pop(1, "R3");
    step(); check_req("R3");
    chk("R3", "tx head after overflow", tx_out_data, txq[0]);
    drain("R3");
    check_req("R3");
  endtask

  task automatic t_tx_thresh();
    wr(2'd0, {4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 4'h3});
    wr(2'd1, 6'b000001);
    for (int l = 0; l <= 5; l++) begin
      step(); check_req("R4");
      push(0, 32'h7700_0000 + l);
    end
    drain("R4");
    check_req("R4");
  endtask

  task automatic t_rx_thresh();
    wr(2'd0, {4'hF, 4'hF, 4'h2, 4'hF, 4'hF, 4'hF});
    wr(2'd1, 6'b001000);
    for (int l = 0; l <= 4; l++) begin
      step(); check_req("R5");
      push(1, 32'h6600_0000 + l);
    end
    drain("R5");
  endtask

  task automatic t_irq_gate();
    wr(2'd0, {4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0});
    wr(2'd1, 6'b000000);
    step(); check_req("R9");
    wr(2'd1, 6'b100000);
    step(); check_req("R8");
    push(1, 32'h1111_0001);
    step(); check_req("R8");
    push(0, 32'h2222_0001); push(0, 32'h2222_0002);
    wr(2'd1, 6'b010000);
    step(); check_req("R8");
    drain("R8");
  endtask

  task automatic t_latency();
    wr(2'd0, {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h2});
    wr(2'd1, 6'b000001);
    push(0, 32'h3300_0001); push(0, 32'h3300_0002);
    step(); check_req("R10");
    push(0, 32'h3300_0003);
    chk("R10", "dma_req[0] one cycle after level change", 32'(dma_req[0]), 1);
    step();
    chk("R10", "dma_req[0] two cycles after level change", 32'(dma_req[0]), 0);
    drain("R10");
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd0, 24'h9A_5C31);
    rd(2'd0, v); chk("R12", "depth readback", v, 32'h009A_5C31);
    wr(2'd1, 6'b101010);
    rd(2'd1, v); chk("R12", "enable readback", v, 32'h2A);
    wr(2'd2, 24'hFF_FFFF);
    rd(2'd0, v); chk("R12", "depth after status write", v, 32'h009A_5C31);
    rd(2'd1, v); chk("R12", "enable after status write", v, 32'h2A);
    step(); check_req("R12");
  endtask

  initial begin
    for (int i = 0; i < 6; i++) dep[i] = '0;
    repeat (3) step();
    rst_n = 1;
    step(); step();
    t_reset();
    t_order();
    t_simul();
    t_tx_thresh();
    t_rx_thresh();
    t_irq_gate();
    t_latency();
    t_regs();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule